// File: doc/BRIEF.md
# Control-Flow Next-PC and Cycle-Cost Unit

This unit sits beside the fetch stage of a small single-issue core. For each instruction it is given the current program counter, a class code and the operands a control-flow decision can depend on: a signed relative offset, a register-pair pointer, a status-register bit selector with polarity, the status flags, two compare operands, a tested data byte, and whether the instruction that follows is one or two words long. It works out the next program counter, whether control flow left the sequential path, and how many clock cycles the instruction costs.

Relative and pointer-based jumps and calls, returns, branches on any single flag, signed and unsigned compare branches, and bit-test and equality skips are covered. Stack traffic is handled elsewhere. For a return the unit only reports the cost and leaves the PC alone, because the stack path replaces it. All results are registered, so they appear one clock after the inputs are presented.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset clears the outputs to next_pc 0, taken 0 and cycles 0. Otherwise every output reflects the inputs sampled at the previous rising clock edge.
- R2: Class 0 (sequential) and the unused codes 11 to 15 give next_pc = cur_pc + 1, taken 0 and cycles 1.
- R3: Class 1 (relative jump) gives next_pc = cur_pc + sign-extended rel_off + 1, taken 1 and cycles 2. Class 2 (relative call) gives the same target with cycles 3.
- R4: Class 3 (pointer jump) loads next_pc from ind_ptr with cycles 2. Class 4 (pointer call) does the same with cycles 3. Both set taken 1.
- R5: Class 5 (return) keeps next_pc equal to cur_pc, sets taken 1 and reports cycles 4.
- R6: Class 6 (flag branch) tests sreg[bit_sel]. With bit_pol 1 it branches when that bit is 1, and with bit_pol 0 it branches when the bit is 0. A taken branch gives cur_pc + offset + 1, taken 1 and cycles 2. A branch not taken gives cur_pc + 1, taken 0 and cycles 1.
- R7: Class 7 (signed compare branch) uses N = sreg bit 2 and V = sreg bit 3. With bit_pol 0 (greater or equal) it branches when N XOR V is 0. With bit_pol 1 (less than) it branches when N XOR V is 1. Targets and costs are as in R6.
- R8: Class 8 (unsigned compare branch) uses the carry in sreg bit 0. With bit_pol 0 (same or higher) it branches when carry is 0. With bit_pol 1 (lower) it branches when carry is 1. Targets and costs are as in R6.
- R9: Class 9 (bit-test skip) skips when test_val[bit_sel] equals bit_pol.
- R10: Class 10 (equality skip) skips when cmp_a equals cmp_b.
- R11: A skip that does not happen gives cur_pc + 1, taken 0 and cycles 1. A skip over a one-word instruction (next_long 0) gives cur_pc + 2, taken 1 and cycles 2. A skip over a two-word instruction (next_long 1) gives cur_pc + 3, taken 1 and cycles 3.
- R12: All PC arithmetic wraps modulo 2^PC_W, including negative offsets below address 0 and increments past the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cur_pc | input | PC_W | Address of the current instruction |
| op_class | input | 4 | Instruction class code |
| rel_off | input | OFF_W | Signed relative offset in words |
| ind_ptr | input | PTR_W | Register-pair pointer target |
| bit_sel | input | SEL_W | Bit index into sreg or test_val |
| bit_pol | input | 1 | Polarity: 1 tests for set, 0 tests for clear |
| sreg | input | DATA_W | Status flags |
| test_val | input | DATA_W | Byte examined by a bit-test skip |
| cmp_a | input | DATA_W | First operand of an equality skip |
| cmp_b | input | DATA_W | Second operand of an equality skip |
| next_long | input | 1 | Following instruction is two words long |
| next_pc | output | PC_W | Registered next program counter |
| taken | output | 1 | Registered flag: control left the sequential path |
| cycles | output | 3 | Registered cycle cost of the instruction |

## Verification
The bound properties relate each registered result to the inputs held during the preceding clock cycle. They therefore rely on the inputs being stable around every rising edge and on op_class being one of the defined codes or an unused code that behaves as sequential. The bench changes every input only on the falling edge and keeps each pattern in place for one full period, so each edge sees exactly one instruction. Properties stay idle until one edge has passed outside reset, which makes sure the values they look back on were not reset values.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int CYC_W   = 3;
    localparam int CLASS_W = 4;

    localparam int FLG_C = 0;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;

    typedef enum logic [CLASS_W-1:0] {
        CL_SEQ   = 4'd0,
        CL_RJMP  = 4'd1,
        CL_RCALL = 4'd2,
        CL_IJMP  = 4'd3,
        CL_ICALL = 4'd4,
        CL_RET   = 4'd5,
        CL_BRFLG = 4'd6,
        CL_BRSGN = 4'd7,
        CL_BRUNS = 4'd8,
        CL_SKBIT = 4'd9,
        CL_SKEQ  = 4'd10
    } op_class_e;

    typedef enum logic [2:0] {
        FL_SEQ,
        FL_REL,
        FL_IND,
        FL_HOLD,
        FL_BRANCH,
        FL_SKIP
    } flow_e;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_FLAG,
        CK_SIGNED,
        CK_UNSIGNED,
        CK_BIT,
        CK_EQ
    } cond_e;

    typedef struct packed {
        flow_e             flow;
        cond_e             cond;
        logic [CYC_W-1:0]  cost;
    } npc_dec_t;

    function automatic npc_dec_t npc_decode(input logic [CLASS_W-1:0] raw);
        npc_dec_t d;
        d.flow = FL_SEQ;
        d.cond = CK_NONE;
        d.cost = 3'd1;
        case (raw)
            CL_RJMP:  begin d.flow = FL_REL;    d.cost = 3'd2; end
            CL_RCALL: begin d.flow = FL_REL;    d.cost = 3'd3; end
            CL_IJMP:  begin d.flow = FL_IND;    d.cost = 3'd2; end
            CL_ICALL: begin d.flow = FL_IND;    d.cost = 3'd3; end
            CL_RET:   begin d.flow = FL_HOLD;   d.cost = 3'd4; end
            CL_BRFLG: begin d.flow = FL_BRANCH; d.cond = CK_FLAG;     end
            CL_BRSGN: begin d.flow = FL_BRANCH; d.cond = CK_SIGNED;   end
            CL_BRUNS: begin d.flow = FL_BRANCH; d.cond = CK_UNSIGNED; end
            CL_SKBIT: begin d.flow = FL_SKIP;   d.cond = CK_BIT;      end
            CL_SKEQ:  begin d.flow = FL_SKIP;   d.cond = CK_EQ;       end
            default:  begin d.flow = FL_SEQ;    d.cost = 3'd1; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  cond_e              cond,
    input  logic [DATA_W-1:0]  sreg,
    input  logic [SEL_W-1:0]   bit_sel,
    input  logic               bit_pol,
    input  logic [DATA_W-1:0]  test_val,
    input  logic [DATA_W-1:0]  cmp_a,
    input  logic [DATA_W-1:0]  cmp_b,
    output logic               hit
);
    logic flag_bit;
    logic sign_lt;
    logic data_bit;

    always_comb begin
        flag_bit = sreg[bit_sel];
        sign_lt  = sreg[FLG_N] ^ sreg[FLG_V];
        data_bit = test_val[bit_sel];
        case (cond)
            CK_FLAG:     hit = (flag_bit == bit_pol);
            CK_SIGNED:   hit = (sign_lt == bit_pol);
            CK_UNSIGNED: hit = (sreg[FLG_C] == bit_pol);
            CK_BIT:      hit = (data_bit == bit_pol);
            CK_EQ:       hit = (cmp_a == cmp_b);
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 12,
    parameter int PTR_W = 16
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [OFF_W-1:0] rel_off,
    input  logic [PTR_W-1:0] ind_ptr,
    output logic [PC_W-1:0]  pc_inc1,
    output logic [PC_W-1:0]  pc_inc2,
    output logic [PC_W-1:0]  pc_inc3,
    output logic [PC_W-1:0]  pc_rel,
    output logic [PC_W-1:0]  pc_ind
);
    logic [PC_W-1:0] off_ext;

    generate
        if (OFF_W < PC_W) begin : g_off_sext
            assign off_ext = {{(PC_W-OFF_W){rel_off[OFF_W-1]}}, rel_off};
        end else begin : g_off_trunc
            assign off_ext = rel_off[PC_W-1:0];
        end

        if (PTR_W < PC_W) begin : g_ptr_zext
            assign pc_ind = {{(PC_W-PTR_W){1'b0}}, ind_ptr};
        end else begin : g_ptr_trunc
            assign pc_ind = ind_ptr[PC_W-1:0];
        end
    endgenerate

    assign pc_inc1 = cur_pc + PC_W'(1);
    assign pc_inc2 = cur_pc + PC_W'(2);
    assign pc_inc3 = cur_pc + PC_W'(3);
    assign pc_rel  = pc_inc1 + off_ext;
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  npc_dec_t          dec,
    input  logic              hit,
    input  logic              next_long,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   pc_inc1,
    input  logic [PC_W-1:0]   pc_inc2,
    input  logic [PC_W-1:0]   pc_inc3,
    input  logic [PC_W-1:0]   pc_rel,
    input  logic [PC_W-1:0]   pc_ind,
    output logic [PC_W-1:0]   sel_pc,
    output logic              sel_taken,
    output logic [CYC_W-1:0]  sel_cycles
);
    always_comb begin
        sel_pc     = pc_inc1;
        sel_taken  = 1'b0;
        sel_cycles = 3'd1;
        case (dec.flow)
            FL_REL: begin
                sel_pc     = pc_rel;
                sel_taken  = 1'b1;
                sel_cycles = dec.cost;
            end
            FL_IND: begin
                sel_pc     = pc_ind;
                sel_taken  = 1'b1;
                sel_cycles = dec.cost;
            end
            FL_HOLD: begin
                sel_pc     = cur_pc;
                sel_taken  = 1'b1;
                sel_cycles = dec.cost;
            end
            FL_BRANCH: begin
                if (hit) begin
                    sel_pc     = pc_rel;
                    sel_taken  = 1'b1;
                    sel_cycles = 3'd2;
                end
            end
            FL_SKIP: begin
                if (hit) begin
                    sel_taken = 1'b1;
                    if (next_long) begin
                        sel_pc     = pc_inc3;
                        sel_cycles = 3'd3;
                    end else begin
                        sel_pc     = pc_inc2;
                        sel_cycles = 3'd2;
                    end
                end
            end
            default: begin
                sel_pc     = pc_inc1;
                sel_taken  = 1'b0;
                sel_cycles = 3'd1;
            end
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int OFF_W  = 12,
    parameter int PTR_W  = 16,
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PC_W-1:0]     cur_pc,
    input  logic [3:0]          op_class,
    input  logic [OFF_W-1:0]    rel_off,
    input  logic [PTR_W-1:0]    ind_ptr,
    input  logic [SEL_W-1:0]    bit_sel,
    input  logic                bit_pol,
    input  logic [DATA_W-1:0]   sreg,
    input  logic [DATA_W-1:0]   test_val,
    input  logic [DATA_W-1:0]   cmp_a,
    input  logic [DATA_W-1:0]   cmp_b,
    input  logic                next_long,
    output logic [PC_W-1:0]     next_pc,
    output logic                taken,
    output logic [2:0]          cycles
);
    npc_dec_t           dec;
    logic               hit;
    logic [PC_W-1:0]    pc_inc1, pc_inc2, pc_inc3, pc_rel, pc_ind;
    logic [PC_W-1:0]    sel_pc;
    logic               sel_taken;
    logic [CYC_W-1:0]   sel_cycles;

    assign dec = npc_decode(op_class);

    npc_cond #(.DATA_W(DATA_W)) i_cond (
        .cond     (dec.cond),
        .sreg     (sreg),
        .bit_sel  (bit_sel),
        .bit_pol  (bit_pol),
        .test_val (test_val),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .hit      (hit)
    );

    npc_target #(.PC_W(PC_W), .OFF_W(OFF_W), .PTR_W(PTR_W)) i_target (
        .cur_pc  (cur_pc),
        .rel_off (rel_off),
        .ind_ptr (ind_ptr),
        .pc_inc1 (pc_inc1),
        .pc_inc2 (pc_inc2),
        .pc_inc3 (pc_inc3),
        .pc_rel  (pc_rel),
        .pc_ind  (pc_ind)
    );

    npc_select #(.PC_W(PC_W)) i_select (
        .dec        (dec),
        .hit        (hit),
        .next_long  (next_long),
        .cur_pc     (cur_pc),
        .pc_inc1    (pc_inc1),
        .pc_inc2    (pc_inc2),
        .pc_inc3    (pc_inc3),
        .pc_rel     (pc_rel),
        .pc_ind     (pc_ind),
        .sel_pc     (sel_pc),
        .sel_taken  (sel_taken),
        .sel_cycles (sel_cycles)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc <= '0;
            taken   <= 1'b0;
            cycles  <= '0;
        end else begin
            next_pc <= sel_pc;
            taken   <= sel_taken;
            cycles  <= sel_cycles;
        end
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int PC_W  = 16,
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [PC_W-1:0]  cur_pc,
    input logic [3:0]       op_class,
    input logic [PTR_W-1:0] ind_ptr,
    input logic [PC_W-1:0]  next_pc,
    input logic             taken,
    input logic [2:0]       cycles
);
    logic primed;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    // R1: a registered cost is always within 1..4 once out of reset
    p_cost_range_r1: assert property (@(posedge clk) disable iff (rst || !primed)
        (cycles >= 3'd1) && (cycles <= 3'd4));

    // R2: sequential class advances by one, not taken
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_class) == 4'd0) |->
        (next_pc == $past(cur_pc) + PC_W'(1)) && !taken && (cycles == 3'd1));

    // R3: relative jump is taken with cost 2
    p_rjmp_cost_r3: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_class) == 4'd1) |-> taken && (cycles == 3'd2));

    // R4: pointer jump and call land on the pointer
    p_ind_target_r4: assert property (@(posedge clk) disable iff (rst || !primed)
        (($past(op_class) == 4'd3) || ($past(op_class) == 4'd4)) |->
        taken && (next_pc == PC_W'($past(ind_ptr))));

    // R5: return holds the PC and costs 4
    p_ret_hold_r5: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_class) == 4'd5) |->
        taken && (cycles == 3'd4) && (next_pc == $past(cur_pc)));

    // R6: any conditional branch costs 2 when taken, 1 otherwise
    p_branch_cost_r6: assert property (@(posedge clk) disable iff (rst || !primed)
        (($past(op_class) >= 4'd6) && ($past(op_class) <= 4'd8)) |->
        (cycles == (taken ? 3'd2 : 3'd1)));

    // R11: a skip advances the PC by exactly its cycle cost
    p_skip_advance_r11: assert property (@(posedge clk) disable iff (rst || !primed)
        (($past(op_class) == 4'd9) || ($past(op_class) == 4'd10)) |->
        ((next_pc - $past(cur_pc)) == PC_W'(cycles)));
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W), .PTR_W(PTR_W)) i_npc_unit_chk (
    .clk      (clk),
    .rst      (rst),
    .cur_pc   (cur_pc),
    .op_class (op_class),
    .ind_ptr  (ind_ptr),
    .next_pc  (next_pc),
    .taken    (taken),
    .cycles   (cycles)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;

    typedef struct packed {
        logic [3:0]  cls;
        logic [15:0] pc;
        logic [11:0] off;
        logic [15:0] ptr;
        logic [2:0]  sel;
        logic        pol;
        logic [7:0]  sr;
        logic [7:0]  tv;
        logic [7:0]  a;
        logic [7:0]  b;
        logic        lng;
        logic [15:0] epc;
        logic        etk;
        logic [2:0]  ecy;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R2 sequential and unused code
        '{4'd0,  16'h0100, 12'h000, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0101, 1'b0, 3'd1, 8'd2},
        '{4'd15, 16'h0100, 12'h000, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0101, 1'b0, 3'd1, 8'd2},
        // R3 relative jump forward and backward, relative call
        '{4'd1,  16'h0100, 12'h010, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0111, 1'b1, 3'd2, 8'd3},
        '{4'd1,  16'h0100, 12'hFFE, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h00FF, 1'b1, 3'd2, 8'd3},
        '{4'd2,  16'h0100, 12'h005, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0106, 1'b1, 3'd3, 8'd3},
        // R4 pointer jump and call
        '{4'd3,  16'h0100, 12'h000, 16'h1234, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h1234, 1'b1, 3'd2, 8'd4},
        '{4'd4,  16'h0100, 12'h000, 16'hABCD, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'hABCD, 1'b1, 3'd3, 8'd4},
        // R5 return
        '{4'd5,  16'h0100, 12'h000, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0100, 1'b1, 3'd4, 8'd5},
        // R6 flag branch: set / not set / clear polarity
        '{4'd6,  16'h0100, 12'h020, 16'h0000, 3'd1, 1'b1, 8'h02, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0121, 1'b1, 3'd2, 8'd6},
        '{4'd6,  16'h0100, 12'h020, 16'h0000, 3'd1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0101, 1'b0, 3'd1, 8'd6},
        '{4'd6,  16'h0100, 12'h020, 16'h0000, 3'd6, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0121, 1'b1, 3'd2, 8'd6},
        // R7 signed: GE with N=V=1, GE fails with N only, LT with V only
        '{4'd7,  16'h0100, 12'h008, 16'h0000, 3'd0, 1'b0, 8'h0C, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0109, 1'b1, 3'd2, 8'd7},
        '{4'd7,  16'h0100, 12'h008, 16'h0000, 3'd0, 1'b0, 8'h04, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0101, 1'b0, 3'd1, 8'd7},
        '{4'd7,  16'h0100, 12'h008, 16'h0000, 3'd0, 1'b1, 8'h08, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0109, 1'b1, 3'd2, 8'd7},
        // R8 unsigned: same-or-higher, lower fails, lower
        '{4'd8,  16'h0100, 12'h008, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0109, 1'b1, 3'd2, 8'd8},
        '{4'd8,  16'h0100, 12'h008, 16'h0000, 3'd0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0101, 1'b0, 3'd1, 8'd8},
        '{4'd8,  16'h0100, 12'h008, 16'h0000, 3'd0, 1'b1, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0109, 1'b1, 3'd2, 8'd8},
        // R9 bit-test skip
        '{4'd9,  16'h0100, 12'h000, 16'h0000, 3'd3, 1'b1, 8'h00, 8'h08, 8'h00, 8'h00, 1'b0, 16'h0102, 1'b1, 3'd2, 8'd9},
        '{4'd9,  16'h0100, 12'h000, 16'h0000, 3'd3, 1'b1, 8'h00, 8'hF7, 8'h00, 8'h00, 1'b0, 16'h0101, 1'b0, 3'd1, 8'd9},
        '{4'd9,  16'h0100, 12'h000, 16'h0000, 3'd0, 1'b0, 8'h00, 8'hFE, 8'h00, 8'h00, 1'b1, 16'h0103, 1'b1, 3'd3, 8'd9},
        // R10 equality skip
        '{4'd10, 16'h0100, 12'h000, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h5A, 8'h5A, 1'b0, 16'h0102, 1'b1, 3'd2, 8'd10},
        '{4'd10, 16'h0100, 12'h000, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h5A, 8'h5B, 1'b1, 16'h0101, 1'b0, 3'd1, 8'd10},
        // R11 skip over a two-word instruction
        '{4'd10, 16'h0100, 12'h000, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h33, 8'h33, 1'b1, 16'h0103, 1'b1, 3'd3, 8'd11},
        // R12 wrap cases
        '{4'd1,  16'hFFF0, 12'h7FF, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h07F0, 1'b1, 3'd2, 8'd12},
        '{4'd0,  16'hFFFF, 12'h000, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 3'd1, 8'd12},
        '{4'd1,  16'h0000, 12'h800, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'hF801, 1'b1, 3'd2, 8'd12},
        '{4'd10, 16'hFFFE, 12'h000, 16'h0000, 3'd0, 1'b0, 8'h00, 8'h00, 8'h11, 8'h11, 1'b1, 16'h0001, 1'b1, 3'd3, 8'd12}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cur_pc;
    logic [3:0]  op_class;
    logic [11:0] rel_off;
    logic [15:0] ind_ptr;
    logic [2:0]  bit_sel;
    logic        bit_pol;
    logic [7:0]  sreg, test_val, cmp_a, cmp_b;
    logic        next_long;
    logic [15:0] next_pc;
    logic        taken;
    logic [2:0]  cycles;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .op_class(op_class),
        .rel_off(rel_off), .ind_ptr(ind_ptr), .bit_sel(bit_sel),
        .bit_pol(bit_pol), .sreg(sreg), .test_val(test_val),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .next_long(next_long),
        .next_pc(next_pc), .taken(taken), .cycles(cycles)
    );

    task automatic apply(input vec_t v);
        cur_pc = v.pc; op_class = v.cls; rel_off = v.off; ind_ptr = v.ptr;
        bit_sel = v.sel; bit_pol = v.pol; sreg = v.sr; test_val = v.tv;
        cmp_a = v.a; cmp_b = v.b; next_long = v.lng;
    endtask

    task automatic expect_out(input string tag, input logic [15:0] epc,
                              input logic etk, input logic [2:0] ecy);
        n_checks++;
        if (next_pc !== epc || taken !== etk || cycles !== ecy) begin
            n_fails++;
            $display("FAIL %s: actual pc=%h taken=%b cycles=%0d expected pc=%h taken=%b cycles=%0d",
                     tag, next_pc, taken, cycles, epc, etk, ecy);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fails++;
        $display("FAIL R1 watchdog: actual run not finished expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        apply(VECS[2]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state even with a jump presented
        expect_out("R1 reset", 16'h0000, 1'b0, 3'd0);
        rst = 1'b0;
        apply(VECS[0]);
        // R1: still reset values before the next edge
        expect_out("R1 latency", 16'h0000, 1'b0, 3'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            expect_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                       VECS[i].epc, VECS[i].etk, VECS[i].ecy);
        end

        // R1: output holds last result until the next edge after a new input
        apply(VECS[7]);
        #1;
        expect_out("R1 hold", VECS[NV-1].epc, VECS[NV-1].etk, VECS[NV-1].ecy);
        @(negedge clk);
        expect_out("R1 update", 16'h0100, 1'b1, 3'd4);

        // R1: mid-run reset clears outputs
        rst = 1'b1;
        @(negedge clk);
        expect_out("R1 mid reset", 16'h0000, 1'b0, 3'd0);
        rst = 1'b0;
        apply(VECS[3]);
        @(negedge clk);
        expect_out("R3 after reset", 16'h00FF, 1'b1, 3'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule